// File: doc/BRIEF.md
# Mesh Minimal-Path Output Selector

This unit sits in the route-computation stage of a two-dimensional mesh router. On a request strobe it compares the coordinates of the current node with those of the packet's destination. It works out which of the four mesh output directions bring the packet closer, and returns them as an ordered candidate list. The order comes from a ranking policy chosen per request: fixed dimension order, larger remaining distance first, least congested link first, or a random pick. A fifth policy appends non-minimal detour outputs after the productive ones. It offers them only while the packet has made fewer detours than a set limit, and never offers a direction that would leave the mesh.

The result is registered and appears one cycle after the strobe. It stays held until the next strobe. The router's allocator walks the list in slot order: slots 0 and 1 carry productive outputs, and slots 2 and 3 carry detours.

Top module: `mesh_route_select`

## Requirements
- R1: One clock cycle after a cycle with `req_i` high, `out_valid_o` is high. In any cycle after one with `req_i` low, `out_valid_o` is low and `local_o`, `cand_dir_o` and `cand_vld_o` keep their previous values.
- R2: While `rst` is high, and on the first cycle after it, all outputs are zero.
- R3: Directions are coded 0 = +x, 1 = −x, 2 = +y, 3 = −y. Slot k uses `cand_dir_o[2k+1:2k]` and `cand_vld_o[k]`. Slots 0/1 hold only directions that reduce the remaining distance. Slot 0 is filled first. Slot 1 is valid only when both the x and y coordinates differ. Every invalid slot reads direction 0.
- R4: When the current coordinates equal the destination, `local_o` is 1 and all four slots are invalid. Otherwise `local_o` is 0.
- R5: Mode 0 (dimension order), and the unused codes 5 to 7, put the x output before the y output.
- R6: Mode 1 puts first the dimension with more hops left. On equal hop counts, x goes first. Example: from (4,3) to (6,10), slot 0 = +y and slot 1 = +x.
- R7: Mode 2 puts first the output with fewer busy virtual channels. The count for direction d is read from `busy_i[d*BUSY_W +: BUSY_W]`. On equal counts, x goes first.
- R8: Mode 3 puts y first when `rand_i` is 1 and x first when it is 0.
- R9: Mode 4 orders the productive outputs as in mode 0. Slots 2 and 3 then take the non-productive directions that stay on the mesh, in ascending code order. This happens only when `defl_hops_i` < `DEFL_MAX` and the node is not the destination. Otherwise slots 2 and 3 are invalid.
- R10: In every mode other than 4, slots 2 and 3 are invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request strobe; inputs are sampled on this cycle |
| cur_x_i | input | COORD_W | Current node x coordinate |
| cur_y_i | input | COORD_W | Current node y coordinate |
| dst_x_i | input | COORD_W | Destination x coordinate |
| dst_y_i | input | COORD_W | Destination y coordinate |
| mode_i | input | 3 | Ranking policy code |
| busy_i | input | 4*BUSY_W | Busy virtual-channel count per output direction |
| rand_i | input | 1 | Random bit for mode 3 |
| defl_hops_i | input | HOP_W | Non-minimal hops already taken by the packet |
| out_valid_o | output | 1 | One-cycle pulse marking a fresh result |
| local_o | output | 1 | Packet has arrived; deliver to the local port |
| cand_dir_o | output | 8 | Four 2-bit direction codes, slot 0 in the low bits |
| cand_vld_o | output | 4 | Valid bit per slot |

## Verification
Two functions can coincide: productive ranking in slots 0/1 and detour filling in slots 2/3. In mode 4 they are computed in the same cycle, and at mesh edges the detour set shrinks. The bench provokes this with random coordinates across the whole mesh and with directed requests at corner nodes. Hop counts are placed on and around the limit. The full four-slot list is judged against a bench model. Detour slots must never repeat a productive direction or point off the mesh.

// File: rtl/mesh_sel_pkg.sv
package mesh_sel_pkg;

    typedef enum logic [1:0] {
        DIR_XP = 2'd0,
        DIR_XN = 2'd1,
        DIR_YP = 2'd2,
        DIR_YN = 2'd3
    } dir_e;

    typedef enum logic [2:0] {
        SEL_DOR  = 3'd0,
        SEL_DIAG = 3'd1,
        SEL_CONG = 3'd2,
        SEL_RAND = 3'd3,
        SEL_DEFL = 3'd4
    } sel_mode_e;

    localparam int NUM_DIRS  = 4;
    localparam int NUM_SLOTS = 4;
    localparam int DIR_W     = 2;

    // productive-direction summary for one request
    typedef struct packed {
        logic at_dest;
        logic x_ok;
        dir_e x_dir;
        logic y_ok;
        dir_e y_dir;
    } prod_t;

    function automatic logic dir_is_productive(input prod_t p, input dir_e d);
        return (p.x_ok && p.x_dir == d) || (p.y_ok && p.y_dir == d);
    endfunction

endpackage

// File: rtl/mesh_min_dirs.sv
module mesh_min_dirs
    import mesh_sel_pkg::*;
#(
    parameter int COORD_W = 4
) (
    input  logic [COORD_W-1:0] cur_x,
    input  logic [COORD_W-1:0] cur_y,
    input  logic [COORD_W-1:0] dst_x,
    input  logic [COORD_W-1:0] dst_y,
    output prod_t              prod,
    output logic [COORD_W-1:0] x_dist,
    output logic [COORD_W-1:0] y_dist
);
    always_comb begin
        prod         = '0;
        prod.x_ok    = (cur_x != dst_x);
        prod.y_ok    = (cur_y != dst_y);
        prod.at_dest = !prod.x_ok && !prod.y_ok;
        prod.x_dir   = (dst_x > cur_x) ? DIR_XP : DIR_XN;
        prod.y_dir   = (dst_y > cur_y) ? DIR_YP : DIR_YN;
        x_dist       = (dst_x > cur_x) ? (dst_x - cur_x) : (cur_x - dst_x);
        y_dist       = (dst_y > cur_y) ? (dst_y - cur_y) : (cur_y - dst_y);
    end
endmodule

// File: rtl/mesh_rank.sv
module mesh_rank
    import mesh_sel_pkg::*;
#(
    parameter int COORD_W = 4,
    parameter int BUSY_W  = 3
) (
    input  prod_t                       prod,
    input  logic [COORD_W-1:0]          x_dist,
    input  logic [COORD_W-1:0]          y_dist,
    input  logic [2:0]                  mode,
    input  logic [NUM_DIRS*BUSY_W-1:0]  busy,
    input  logic                        rnd,
    output dir_e                        first_dir,
    output dir_e                        second_dir,
    output logic [1:0]                  vld
);
    logic [BUSY_W-1:0] busy_x, busy_y;
    logic              y_pref;

    always_comb begin
        busy_x = busy[prod.x_dir*BUSY_W +: BUSY_W];
        busy_y = busy[prod.y_dir*BUSY_W +: BUSY_W];
        unique case (mode)
            SEL_DIAG: y_pref = (y_dist > x_dist);
            SEL_CONG: y_pref = (busy_y < busy_x);
            SEL_RAND: y_pref = rnd;
            default:  y_pref = 1'b0;
        endcase
    end

    always_comb begin
        first_dir  = DIR_XP;
        second_dir = DIR_XP;
        vld        = 2'b00;
        if (prod.x_ok && prod.y_ok) begin
            first_dir  = y_pref ? prod.y_dir : prod.x_dir;
            second_dir = y_pref ? prod.x_dir : prod.y_dir;
            vld        = 2'b11;
        end else if (prod.x_ok) begin
            first_dir = prod.x_dir;
            vld       = 2'b01;
        end else if (prod.y_ok) begin
            first_dir = prod.y_dir;
            vld       = 2'b01;
        end
    end
endmodule

// File: rtl/mesh_deflect.sv
module mesh_deflect
    import mesh_sel_pkg::*;
#(
    parameter int COORD_W  = 4,
    parameter int MESH_X   = 16,
    parameter int MESH_Y   = 16,
    parameter int HOP_W    = 3,
    parameter int DEFL_MAX = 2
) (
    input  logic [COORD_W-1:0] cur_x,
    input  logic [COORD_W-1:0] cur_y,
    input  prod_t              prod,
    input  logic [2:0]         mode,
    input  logic [HOP_W-1:0]   hops,
    output dir_e               defl_dir [2],
    output logic [1:0]         vld
);
    localparam logic [COORD_W-1:0] X_LAST  = COORD_W'(MESH_X - 1);
    localparam logic [COORD_W-1:0] Y_LAST  = COORD_W'(MESH_Y - 1);
    localparam logic [HOP_W-1:0]   HOP_LIM = HOP_W'(DEFL_MAX);

    logic [NUM_DIRS-1:0] on_mesh;
    logic [NUM_DIRS-1:0] eligible;
    logic                enable;

    assign on_mesh[DIR_XP] = (cur_x < X_LAST);
    assign on_mesh[DIR_XN] = (cur_x != '0);
    assign on_mesh[DIR_YP] = (cur_y < Y_LAST);
    assign on_mesh[DIR_YN] = (cur_y != '0);
    assign enable = (mode == SEL_DEFL) && (hops < HOP_LIM) && !prod.at_dest;

    for (genvar d = 0; d < NUM_DIRS; d++) begin : g_elig
        assign eligible[d] = enable && on_mesh[d] && !dir_is_productive(prod, dir_e'(d));
    end

    always_comb begin
        defl_dir[0] = DIR_XP;
        defl_dir[1] = DIR_XP;
        vld         = 2'b00;
        for (int d = 0; d < NUM_DIRS; d++) begin
            if (eligible[d]) begin
                if (!vld[0]) begin
                    defl_dir[0] = dir_e'(d);
                    vld[0]      = 1'b1;
                end else if (!vld[1]) begin
                    defl_dir[1] = dir_e'(d);
                    vld[1]      = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mesh_route_select.sv
module mesh_route_select
    import mesh_sel_pkg::*;
#(
    parameter int MESH_X   = 16,
    parameter int MESH_Y   = 16,
    parameter int COORD_W  = 4,
    parameter int BUSY_W   = 3,
    parameter int HOP_W    = 3,
    parameter int DEFL_MAX = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_i,
    input  logic [COORD_W-1:0]         cur_x_i,
    input  logic [COORD_W-1:0]         cur_y_i,
    input  logic [COORD_W-1:0]         dst_x_i,
    input  logic [COORD_W-1:0]         dst_y_i,
    input  logic [2:0]                 mode_i,
    input  logic [4*BUSY_W-1:0]        busy_i,
    input  logic                       rand_i,
    input  logic [HOP_W-1:0]           defl_hops_i,
    output logic                       out_valid_o,
    output logic                       local_o,
    output logic [7:0]                 cand_dir_o,
    output logic [3:0]                 cand_vld_o
);
    prod_t              prod;
    logic [COORD_W-1:0] x_dist, y_dist;
    dir_e               rank_first, rank_second;
    logic [1:0]         rank_vld;
    dir_e               defl_dir [2];
    logic [1:0]         defl_vld;
    logic [7:0]         dir_next;

    mesh_min_dirs #(.COORD_W(COORD_W)) u_min (
        .cur_x(cur_x_i), .cur_y(cur_y_i), .dst_x(dst_x_i), .dst_y(dst_y_i),
        .prod(prod), .x_dist(x_dist), .y_dist(y_dist)
    );

    mesh_rank #(.COORD_W(COORD_W), .BUSY_W(BUSY_W)) u_rank (
        .prod(prod), .x_dist(x_dist), .y_dist(y_dist), .mode(mode_i),
        .busy(busy_i), .rnd(rand_i),
        .first_dir(rank_first), .second_dir(rank_second), .vld(rank_vld)
    );

    mesh_deflect #(
        .COORD_W(COORD_W), .MESH_X(MESH_X), .MESH_Y(MESH_Y),
        .HOP_W(HOP_W), .DEFL_MAX(DEFL_MAX)
    ) u_defl (
        .cur_x(cur_x_i), .cur_y(cur_y_i), .prod(prod), .mode(mode_i),
        .hops(defl_hops_i), .defl_dir(defl_dir), .vld(defl_vld)
    );

    assign dir_next = {defl_dir[1], defl_dir[0], rank_second, rank_first};

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid_o <= 1'b0;
            local_o     <= 1'b0;
            cand_dir_o  <= '0;
            cand_vld_o  <= '0;
        end else begin
            out_valid_o <= req_i;
            if (req_i) begin
                local_o    <= prod.at_dest;
                cand_dir_o <= dir_next;
                cand_vld_o <= {defl_vld, rank_vld};
            end
        end
    end
endmodule

// File: rtl/mesh_route_select_chk.sv
module mesh_route_select_chk #(
    parameter int COORD_W  = 4,
    parameter int HOP_W    = 3,
    parameter int DEFL_MAX = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               req_i,
    input logic [COORD_W-1:0] cur_x_i,
    input logic [COORD_W-1:0] cur_y_i,
    input logic [COORD_W-1:0] dst_x_i,
    input logic [COORD_W-1:0] dst_y_i,
    input logic [2:0]         mode_i,
    input logic [HOP_W-1:0]   defl_hops_i,
    input logic               out_valid_o,
    input logic               local_o,
    input logic [7:0]         cand_dir_o,
    input logic [3:0]         cand_vld_o
);
    localparam logic [HOP_W-1:0] HOP_LIM = HOP_W'(DEFL_MAX);

    p_valid_pulse_r1: assert property (@(posedge clk) disable iff (rst)
        req_i |=> out_valid_o);

    p_idle_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !req_i |=> (!out_valid_o && $stable(cand_dir_o) && $stable(cand_vld_o) && $stable(local_o)));

    p_local_detect_r4: assert property (@(posedge clk) disable iff (rst)
        (req_i && cur_x_i == dst_x_i && cur_y_i == dst_y_i) |=> local_o);

    p_local_empty_r4: assert property (@(posedge clk) disable iff (rst)
        local_o |-> (cand_vld_o == 4'b0000));

    p_slot_fill_r3: assert property (@(posedge clk) disable iff (rst)
        cand_vld_o[1] |-> (cand_vld_o[0] && (cand_dir_o[3] != cand_dir_o[1])));

    p_dor_x_first_r5: assert property (@(posedge clk) disable iff (rst)
        (req_i && mode_i == 3'd0 && cur_x_i != dst_x_i) |=> (cand_dir_o[1] == 1'b0));

    p_hop_limit_r9: assert property (@(posedge clk) disable iff (rst)
        (req_i && defl_hops_i >= HOP_LIM) |=> (cand_vld_o[3:2] == 2'b00));

    p_no_defl_r10: assert property (@(posedge clk) disable iff (rst)
        (req_i && mode_i != 3'd4) |=> (cand_vld_o[3:2] == 2'b00));
endmodule

bind mesh_route_select mesh_route_select_chk #(
    .COORD_W(COORD_W), .HOP_W(HOP_W), .DEFL_MAX(DEFL_MAX)
) u_chk (
    .clk(clk), .rst(rst), .req_i(req_i),
    .cur_x_i(cur_x_i), .cur_y_i(cur_y_i), .dst_x_i(dst_x_i), .dst_y_i(dst_y_i),
    .mode_i(mode_i), .defl_hops_i(defl_hops_i),
    .out_valid_o(out_valid_o), .local_o(local_o),
    .cand_dir_o(cand_dir_o), .cand_vld_o(cand_vld_o)
);

// File: tb/tb_mesh_route_select.sv
module tb_mesh_route_select;
    localparam int MX = 16, MY = 16, CW = 4, BW = 3, HW = 3, DMAX = 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            req_i = 1'b0;
    logic [CW-1:0]   cur_x_i = '0, cur_y_i = '0, dst_x_i = '0, dst_y_i = '0;
    logic [2:0]      mode_i = '0;
    logic [4*BW-1:0] busy_i = '0;
    logic            rand_i = 1'b0;
    logic [HW-1:0]   defl_hops_i = '0;
    logic            out_valid_o, local_o;
    logic [7:0]      cand_dir_o;
    logic [3:0]      cand_vld_o;

    int total = 0, bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mesh_route_select #(.MESH_X(MX), .MESH_Y(MY), .COORD_W(CW), .BUSY_W(BW),
                        .HOP_W(HW), .DEFL_MAX(DMAX)) dut (.*);

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // independent reference of the requirements
    function automatic logic [12:0] model(input int cx, cy, dx, dy, md, input logic [4*BW-1:0] bz,
                                          input logic rb, input int hp);
        int xd, yd, xdist, ydist, n, bx, by;
        logic yfirst, xok, yok, loc;
        logic [7:0] dirs;
        logic [3:0] v;
        bit prodd [4];
        bit onm [4];
        dirs = '0; v = '0;
        xok = (cx != dx); yok = (cy != dy); loc = !xok && !yok;
        xd = (dx > cx) ? 0 : 1; yd = (dy > cy) ? 2 : 3;
        xdist = (dx > cx) ? dx - cx : cx - dx;
        ydist = (dy > cy) ? dy - cy : cy - dy;
        bx = int'(bz[xd*BW +: BW]); by = int'(bz[yd*BW +: BW]);
        case (md)
            1: yfirst = (ydist > xdist);
            2: yfirst = (by < bx);
            3: yfirst = rb;
            default: yfirst = 1'b0;
        endcase
        if (xok && yok) begin
            dirs[1:0] = yfirst ? 2'(yd) : 2'(xd);
            dirs[3:2] = yfirst ? 2'(xd) : 2'(yd);
            v[1:0] = 2'b11;
        end else if (xok) begin dirs[1:0] = 2'(xd); v[0] = 1'b1; end
        else if (yok) begin dirs[1:0] = 2'(yd); v[0] = 1'b1; end
        if (md == 4 && hp < DMAX && !loc) begin
            for (int d = 0; d < 4; d++) prodd[d] = (xok && d == xd) || (yok && d == yd);
            onm[0] = cx < MX - 1; onm[1] = cx > 0; onm[2] = cy < MY - 1; onm[3] = cy > 0;
            n = 0;
            for (int d = 0; d < 4; d++) begin
                if (!prodd[d] && onm[d] && n < 2) begin
                    dirs[4 + 2*n +: 2] = 2'(d);
                    v[2 + n] = 1'b1;
                    n++;
                end
            end
        end
        return {loc, dirs, v};
    endfunction

    function automatic string tag(input int cx, cy, dx, dy, md);
        if (cx == dx && cy == dy) return "R4";
        case (md)
            1: return "R6"; 2: return "R7"; 3: return "R8"; 4: return "R9";
            default: return "R5/R3/R10";
        endcase
    endfunction

    task automatic run_req(input int cx, cy, dx, dy, md, input logic [4*BW-1:0] bz,
                           input logic rb, input int hp, input string tg);
        logic [12:0] exp;
        logic [12:0] held;
        @(negedge clk);
        cur_x_i = CW'(cx); cur_y_i = CW'(cy); dst_x_i = CW'(dx); dst_y_i = CW'(dy);
        mode_i = 3'(md); busy_i = bz; rand_i = rb; defl_hops_i = HW'(hp); req_i = 1'b1;
        exp = model(cx, cy, dx, dy, md, bz, rb, hp);
        @(negedge clk);
        req_i = 1'b0;
        check("R1 valid", {15'd0, out_valid_o}, 16'd1);
        check(tg, {3'd0, local_o, cand_dir_o, cand_vld_o}, {3'd0, exp});
        held = {local_o, cand_dir_o, cand_vld_o};
        cur_x_i = CW'($urandom_range(MX-1)); dst_x_i = CW'($urandom_range(MX-1));
        mode_i = 3'($urandom_range(7));
        @(negedge clk);
        check("R1 hold", {2'd0, out_valid_o, local_o, cand_dir_o, cand_vld_o}, {3'd0, held});
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        check("R2 reset", {2'd0, out_valid_o, local_o, cand_dir_o, cand_vld_o}, 16'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R2 after reset", {2'd0, out_valid_o, local_o, cand_dir_o, cand_vld_o}, 16'd0);
        // directed corners
        run_req(4, 3, 6, 10, 1, '0, 1'b0, 0, "R6 example");
        run_req(2, 2, 5, 5, 1, '0, 1'b0, 0, "R6 tie");
        run_req(7, 7, 7, 7, 4, '0, 1'b0, 0, "R4 local");
        run_req(3, 3, 9, 1, 2, {3'd1, 3'd5, 3'd4, 3'd5}, 1'b0, 0, "R7 y less busy");
        run_req(3, 3, 9, 1, 2, {3'd4, 3'd5, 3'd4, 3'd4}, 1'b0, 0, "R7 tie");
        run_req(8, 8, 2, 2, 3, '0, 1'b1, 0, "R8 rand1");
        run_req(8, 8, 2, 2, 3, '0, 1'b0, 0, "R8 rand0");
        run_req(0, 0, 0, 5, 4, '0, 1'b0, 0, "R9 corner");
        run_req(15, 15, 3, 15, 4, '0, 1'b0, 1, "R9 far corner");
        run_req(5, 5, 9, 9, 4, '0, 1'b0, 2, "R9 hop limit");
        run_req(5, 5, 9, 2, 6, '0, 1'b1, 0, "R5 unused code");
        run_req(5, 5, 9, 2, 0, '0, 1'b0, 0, "R10 no detour");
        for (int i = 0; i < 1500; i++) begin
            int cx, cy, dx, dy, md, hp;
            cx = $urandom_range(MX-1); cy = $urandom_range(MY-1);
            dx = ($urandom_range(7) == 0) ? cx : $urandom_range(MX-1);
            dy = ($urandom_range(7) == 0) ? cy : $urandom_range(MY-1);
            md = $urandom_range(7); hp = $urandom_range(3);
            run_req(cx, cy, dx, dy, md, 12'($urandom), 1'($urandom), hp, tag(cx, cy, dx, dy, md));
        end
        done = 1'b1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (100000) @(posedge clk);
                bad++; total++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule